// File: doc/BRIEF.md
# Dual asynchronous SRAM access sequencer

This block connects a synchronous host to two external asynchronous SRAM chips. Both chips sit on one shared address bus and one shared data bus, and each chip has its own enable. The host hands over one byte access at a time on a valid/ready port. The lowest bit of the host address picks the chip. The remaining bits form the 19-bit word address that both chips see.

Each access runs as a fixed series of phases, and each phase is counted in whole clock cycles by a parameter. A read waits for the chip's enable-to-data delay and then samples the bus. It then keeps both enables off and the bus undriven for a turnaround gap, because the chip keeps driving data for a while after its enable drops. A write drives address and data first, raises the write strobe only after a setup interval, holds the strobe for a minimum width, and drops it before the access ends. This leaves a hold interval with address and data unchanged.

Back-pressure rules: `req_ready` is high only while no access is in flight. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the request inputs are ignored and may change freely. The host cannot stall the result: `done` is a single-cycle pulse with no handshake.

Top module: `sram_pair_ctrl`

## Requirements
- R1: `req_ready` is high when idle and after reset. It falls on the edge that accepts a request and rises again in the cycle where `done` is high. A `req_valid` seen while `req_ready` is low has no effect on the memory pins.
- R2: Address bit 0 selects the chip: 0 raises `mem_en[0]`, 1 raises `mem_en[1]`. `mem_addr` equals request address bits 19..1 and stays constant through the whole access. At most one enable is high in any cycle.
- R3: For T_EN_SETUP cycles after acceptance, the address is driven and both enables stay low. When T_EN_SETUP is 0, the enable rises in the first cycle after acceptance.
- R4: A read holds the selected enable high for exactly T_RD_DATA cycles. It captures `mem_dq_in` at the edge that ends the last of these cycles and presents that byte on `rd_data` in the `done` cycle.
- R5: After a read enable falls, both enables and `mem_dq_oe` stay low for T_RD_OFF cycles before `done` is raised.
- R6: A write holds the selected enable and `mem_dq_oe` high, with the byte on `mem_dq_out`, for T_WR_SETUP cycles before `mem_wr` rises.
- R7: `mem_wr` is high for exactly T_WR_PULSE consecutive cycles per write.
- R8: After `mem_wr` falls, the enable, `mem_dq_oe`, address and data stay unchanged for T_WR_HOLD cycles. After that, the enable and `mem_dq_oe` drop in the `done` cycle.
- R9: `mem_dq_oe` is high only during the setup, strobe and hold phases of a write. `mem_wr` never rises during a read.
- R10: `done` is high for exactly one cycle. It comes T_EN_SETUP+T_RD_DATA+T_RD_OFF cycles after acceptance for a read and T_EN_SETUP+T_WR_SETUP+T_WR_PULSE+T_WR_HOLD cycles after acceptance for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request can transfer |
| req_addr | input | ADDR_W (20) | Byte address; bit 0 chooses the chip |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W (8) | Byte to write |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | DATA_W (8) | Byte read, valid with `done` |
| mem_addr | output | ADDR_W-1 (19) | Shared word address bus |
| mem_en | output | 2 | Per-chip enable, active high |
| mem_wr | output | 1 | Write strobe, active high |
| mem_dq_out | output | DATA_W (8) | Data driven toward the chips |
| mem_dq_oe | output | 1 | Output enable for the shared data bus |
| mem_dq_in | input | DATA_W (8) | Data sampled from the shared bus |

## Verification
The main function is swept over every word 0..15 in both chips. Writes carry distinct per-chip bytes and are followed by reads, so a wrong chip select or a wrong word shows up as a wrong byte. The chip model returns a poison byte until the enable has been high for the read delay, so sampling one cycle early is told apart from sampling on time. An all-ones address checks the full 19-bit word path. An access with `req_valid` held high while busy checks that back-pressure really blocks a second transfer. Every cycle of every access is compared against the phase pattern derived from the interval parameters. This separates an off-by-one in any single phase from the others.

// File: rtl/sram_pair_pkg.sv
package sram_pair_pkg;

  // One-hot phase encoding; each output decode reads a single bit set.
  typedef enum logic [6:0] {
    ST_IDLE     = 7'b000_0001,
    ST_ASETUP   = 7'b000_0010,
    ST_RD_WAIT  = 7'b000_0100,
    ST_RD_OFF   = 7'b000_1000,
    ST_WR_SETUP = 7'b001_0000,
    ST_WR_PULSE = 7'b010_0000,
    ST_WR_HOLD  = 7'b100_0000
  } seq_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_bank_decode.sv
module sram_bank_decode #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic [ADDR_W-1:0]        addr,
  output logic [ADDR_W-SEL_W-1:0]  word,
  output logic [NUM_BANKS-1:0]     bank_oh
);
  localparam int unsigned SEL_W = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS);

  assign word = addr[ADDR_W-1:SEL_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    assign bank_oh[b] = (addr[SEL_W-1:0] == SEL_W'(b));
  end
endmodule

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_pair_pkg::*;
#(
  parameter int unsigned T_EN_SETUP = 0,
  parameter int unsigned T_RD_DATA  = 2,
  parameter int unsigned T_RD_OFF   = 1,
  parameter int unsigned T_WR_SETUP = 1,
  parameter int unsigned T_WR_PULSE = 2,
  parameter int unsigned T_WR_HOLD  = 1,
  parameter int unsigned CNT_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             op_write,
  input  logic             tmr_expired,
  output seq_state_e       state,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);
  localparam bit HAS_EN_SETUP = (T_EN_SETUP != 0);

  seq_state_e state_q, state_d;

  function automatic int unsigned phase_len(input seq_state_e s);
    case (s)
      ST_ASETUP:   return T_EN_SETUP;
      ST_RD_WAIT:  return T_RD_DATA;
      ST_RD_OFF:   return T_RD_OFF;
      ST_WR_SETUP: return T_WR_SETUP;
      ST_WR_PULSE: return T_WR_PULSE;
      ST_WR_HOLD:  return T_WR_HOLD;
      default:     return 1;
    endcase
  endfunction

  assign accept = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (HAS_EN_SETUP)   state_d = ST_ASETUP;
          else if (req_write) state_d = ST_WR_SETUP;
          else                state_d = ST_RD_WAIT;
        end
      end
      ST_ASETUP:   if (tmr_expired) state_d = op_write ? ST_WR_SETUP : ST_RD_WAIT;
      ST_RD_WAIT:  if (tmr_expired) state_d = ST_RD_OFF;
      ST_RD_OFF:   if (tmr_expired) state_d = ST_IDLE;
      ST_WR_SETUP: if (tmr_expired) state_d = ST_WR_PULSE;
      ST_WR_PULSE: if (tmr_expired) state_d = ST_WR_HOLD;
      ST_WR_HOLD:  if (tmr_expired) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // Each phase lasts exactly phase_len cycles: load len-1 on entry.
  assign tmr_load = (state_d != state_q);
  assign tmr_val  = CNT_W'(phase_len(state_d) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/sram_pair_ctrl.sv
module sram_pair_ctrl
  import sram_pair_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned T_EN_SETUP = 0,
  parameter int unsigned T_RD_DATA  = 2,
  parameter int unsigned T_RD_OFF   = 1,
  parameter int unsigned T_WR_SETUP = 1,
  parameter int unsigned T_WR_PULSE = 2,
  parameter int unsigned T_WR_HOLD  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-2:0] mem_addr,
  output logic [1:0]        mem_en,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned WORD_W    = ADDR_W - 1;
  localparam int unsigned MAX_T     = max2(max2(max2(T_EN_SETUP, T_RD_DATA), max2(T_RD_OFF, T_WR_SETUP)),
                                           max2(T_WR_PULSE, T_WR_HOLD));
  localparam int unsigned CNT_W     = (MAX_T < 2) ? 1 : $clog2(MAX_T);

  logic [ADDR_W-1:0]    addr_q;
  logic                 write_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [DATA_W-1:0]    rdata_q;
  logic                 done_q;
  seq_state_e           state;
  logic                 accept;
  logic                 tmr_load;
  logic                 tmr_expired;
  logic [CNT_W-1:0]     tmr_val;
  logic [WORD_W-1:0]    word;
  logic [NUM_BANKS-1:0] bank_oh;
  logic                 en_phase;
  logic                 drive_phase;

  sram_seq_fsm #(
    .T_EN_SETUP (T_EN_SETUP),
    .T_RD_DATA  (T_RD_DATA),
    .T_RD_OFF   (T_RD_OFF),
    .T_WR_SETUP (T_WR_SETUP),
    .T_WR_PULSE (T_WR_PULSE),
    .T_WR_HOLD  (T_WR_HOLD),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .op_write    (write_q),
    .tmr_expired (tmr_expired),
    .state       (state),
    .accept      (accept),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val)
  );

  sram_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_bank_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_decode (
    .addr    (addr_q),
    .word    (word),
    .bank_oh (bank_oh)
  );

  // Request capture: address and data are frozen for the whole access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      write_q <= req_write;
      wdata_q <= req_wdata;
    end
  end

  // Read capture on the last enable-to-data cycle; done after the final phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if ((state == ST_RD_WAIT) && tmr_expired) rdata_q <= mem_dq_in;
      done_q <= tmr_expired && ((state == ST_RD_OFF) || (state == ST_WR_HOLD));
    end
  end

  assign en_phase    = (state == ST_RD_WAIT) || (state == ST_WR_SETUP) ||
                       (state == ST_WR_PULSE) || (state == ST_WR_HOLD);
  assign drive_phase = (state == ST_WR_SETUP) || (state == ST_WR_PULSE) ||
                       (state == ST_WR_HOLD);

  assign req_ready  = (state == ST_IDLE);
  assign done       = done_q;
  assign rd_data    = rdata_q;
  assign mem_addr   = word;
  assign mem_en     = bank_oh & {NUM_BANKS{en_phase}};
  assign mem_wr     = (state == ST_WR_PULSE);
  assign mem_dq_oe  = drive_phase;
  assign mem_dq_out = wdata_q;
endmodule

// File: rtl/sram_pair_ctrl_checker.sv
module sram_pair_ctrl_checker #(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned T_WR_PULSE = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic [ADDR_W-2:0] mem_addr,
  input logic [1:0]        mem_en,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  int unsigned wr_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_run <= 0;
    else if (mem_wr) wr_run <= wr_run + 1;
    else             wr_run <= 0;
  end

  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mem_en) <= 1);  // R2

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));  // R2

  AST_BUSY_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_en) |-> !req_ready);  // R1

  AST_STROBE_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_dq_oe && (|mem_en)));  // R9

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr && wr_run != 0) |-> (wr_run == T_WR_PULSE));  // R7

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));  // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R10
endmodule

bind sram_pair_ctrl sram_pair_ctrl_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .T_WR_PULSE (T_WR_PULSE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .done       (done),
  .mem_addr   (mem_addr),
  .mem_en     (mem_en),
  .mem_wr     (mem_wr),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_pair_ctrl_bench.sv
module sram_pair_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ES = 1;
  localparam int RD = 2;
  localparam int OFF = 2;
  localparam int WS = 1;
  localparam int WP = 2;
  localparam int WH = 1;
  localparam int B_RD = ES + RD + OFF;
  localparam int B_WR = ES + WS + WP + WH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        done;
  logic [7:0]  rd_data;
  logic [18:0] mem_addr;
  logic [1:0]  mem_en;
  logic        mem_wr;
  logic [7:0]  mem_dq_out;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_in;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_pair_ctrl #(
    .T_EN_SETUP(ES), .T_RD_DATA(RD), .T_RD_OFF(OFF),
    .T_WR_SETUP(WS), .T_WR_PULSE(WP), .T_WR_HOLD(WH)
  ) u_sram_pair_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .mem_addr(mem_addr), .mem_en(mem_en),
    .mem_wr(mem_wr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  function automatic logic [7:0] init_val(input int b, input int idx);
    return 8'((idx * 3) + (b * 64) + 17);
  endfunction

  // Chip model: poison byte until the enable has been high RD cycles.
  logic [7:0] chip_mem [0:1][0:63];
  logic [7:0] shadow   [0:1][0:63];
  int   en_cnt;
  logic prev_wr;

  always @(negedge clk) begin
    if (!rst_n) begin
      en_cnt  <= 0;
      prev_wr <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < 64; i++) chip_mem[b][i] <= init_val(b, i);
    end else begin
      en_cnt  <= (|mem_en) ? en_cnt + 1 : 0;
      prev_wr <= mem_wr;
      if (prev_wr && !mem_wr && (|mem_en))
        chip_mem[mem_en[1]][mem_addr[5:0]] <= mem_dq_out;
    end
  end

  assign mem_dq_in = ((|mem_en) && !mem_dq_oe && en_cnt >= RD) ?
                     chip_mem[mem_en[1]][mem_addr[5:0]] : 8'hEE;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  // One access, checked cycle by cycle against the phase pattern.
  task automatic access(input logic [19:0] a, input bit w, input logic [7:0] d,
                        input bit poke);
    int          busy = w ? B_WR : B_RD;
    int          en_len = w ? (WS + WP + WH) : RD;
    logic [1:0]  oh = a[0] ? 2'b10 : 2'b01;
    logic [7:0]  exp_rd = shadow[a[0]][a[6:1]];
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d;
    chk(req_ready == 1'b1, "R1", "ready before accept", req_ready, 1);
    for (int i = 1; i <= busy + 1; i++) begin
      @(negedge clk);
      req_valid = (poke && i <= busy);
      if (poke) begin req_addr = ~a; req_write = ~w; req_wdata = ~d; end
      begin
        logic [1:0] e_en = (i > ES && i <= ES + en_len) ? oh : 2'b00;
        bit e_oe = w && i > ES && i <= busy;
        bit e_wr = w && i > ES + WS && i <= ES + WS + WP;
        bit e_last = (i == busy + 1);
        if (w) chk(mem_en == e_en, i <= ES ? "R3" : "R6", "write enable", mem_en, e_en);
        else   chk(mem_en == e_en, i <= ES ? "R3" : (i <= ES + RD ? "R4" : "R5"), "read enable", mem_en, e_en);
        chk(mem_dq_oe == e_oe, w ? "R8" : "R9", "data drive", mem_dq_oe, e_oe);
        chk(mem_wr == e_wr, w ? "R7" : "R9", "write strobe", mem_wr, e_wr);
        chk(req_ready == e_last, "R1", "ready", req_ready, e_last);
        chk(done == e_last, "R10", "done", done, e_last);
        if (i <= busy) begin
          chk(mem_addr == a[19:1], "R2", "word address", mem_addr, a[19:1]);
          if (e_oe) chk(mem_dq_out == d, "R6", "write byte", mem_dq_out, d);
        end
        if (e_last && !w) chk(rd_data == exp_rd, "R4", "read byte", rd_data, exp_rd);
      end
    end
    req_valid = 1'b0;
    if (w) shadow[a[0]][a[6:1]] = d;
    if (poke) begin
      @(negedge clk);
      chk(req_ready == 1'b1 && mem_en == 2'b00, "R1", "busy-time request ignored",
          {req_ready, mem_en}, 3'b100);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 64; i++) shadow[b][i] = init_val(b, i);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
    chk(mem_en == 2'b00 && !mem_wr && !mem_dq_oe, "R9", "reset pins idle",
        {mem_en, mem_wr, mem_dq_oe}, 0);
    chk(done == 1'b0, "R10", "reset done", done, 0);
    rst_n = 1'b1;

    // Untouched contents first, then a write/read sweep over both chips.
    access(20'h0000B, 1'b0, 8'h00, 1'b0);
    for (int w = 0; w < 16; w++)
      for (int b = 0; b < 2; b++)
        access(20'((w << 1) | b), 1'b1, 8'((w * 29) + (b * 101) + 7), 1'b0);
    for (int w = 0; w < 16; w++)
      for (int b = 0; b < 2; b++)
        access(20'((w << 1) | b), 1'b0, 8'h00, 1'b0);

    // Full-width word address on chip 1, then chip 0 at the same word.
    access(20'hFFFFF, 1'b1, 8'h3C, 1'b0);
    access(20'hFFFFF, 1'b0, 8'h00, 1'b0);
    access(20'hFFFFE, 1'b0, 8'h00, 1'b0);

    // Back-pressure: valid held high during busy cycles.
    access(20'h00021, 1'b1, 8'h5A, 1'b1);
    access(20'h00021, 1'b0, 8'h00, 1'b1);

    finish_run();
  end
endmodule